// File: doc/BRIEF.md
# HDLC Receive Descriptor Writer

This block sits behind an HDLC receiver. That receiver has already removed flags and bit stuffing, applied address filtering and computed the frame check. The block takes the accepted byte stream with its end-of-frame strobe and the CRC-error and abort qualifiers. It places the bytes into a small ring of receive buffers. Each buffer has a descriptor kept in local registers. A descriptor holds a control nibble (empty, interrupt enable, wrap, last-in-frame), a length field and a status field. The block only fills descriptors that are marked empty. It closes each one as its buffer fills, and it closes the final one of a frame with the last-in-frame flag, the status and the total frame length.

A frame may run across several buffers. The byte count used for the maximum-length check keeps running across buffer boundaries. Once the programmed limit is reached, further bytes are thrown away and the frame is flagged. When the block needs a descriptor that is still owned by software, it drops the rest of the frame, pulses a busy event and leaves that descriptor untouched. Descriptors are armed through a simple arm port. Their contents, including every stored byte, can be read back combinationally through a read port.

Interface contract: `rxEnd` is never asserted in the same cycle as `rxValid`, and `maxLen` is at least 1. Software arms only descriptors the writer is not using in that cycle.

Top module: `hdlc_rx_bd_writer`

## Requirements
- R1: After reset every descriptor reads back with control nibble 0, length 0, status 0 and zeroed buffer bytes, and all three event outputs are low.
- R2: An arm request sets the chosen descriptor's empty bit (control bit 0), copies the interrupt-enable (bit 1) and wrap (bit 2) inputs, and clears last (bit 3), length and status.
- R3: A frame's bytes go, in arrival order, into consecutive byte positions of the descriptor under the ring pointer. If that descriptor is not empty when the frame's first byte arrives, the whole frame is dropped, `busyIrq` pulses once and no descriptor changes.
- R4: When a buffer receives its last byte, its empty bit clears and its length reads the buffer size. `bufIrq` pulses for one cycle, on the edge after that byte, only if the descriptor's interrupt-enable bit is set.
- R5: The ring pointer advances by one after a descriptor is closed. It returns to descriptor 0 after a descriptor whose wrap bit is set or after the highest-numbered descriptor.
- R6: If a frame needs a further buffer and the next descriptor is not empty, the rest of the frame is discarded and `busyIrq` pulses once. That descriptor is left unchanged, and the already filled buffers stay closed without the last bit.
- R7: At frame end the descriptor holding the frame's last stored byte gets last set and empty cleared, and its length becomes the total number of bytes stored for the whole frame. `frameIrq` pulses on the edge after `rxEnd` if its interrupt-enable bit is set.
- R8: The final descriptor's status word carries the CRC error in bit 0, the abort in bit 1 and the length violation in bit 2, each taken at frame end.
- R9: Bytes arriving after `maxLen` bytes of a frame have been stored are discarded, the frame is reported with length `maxLen`, and the length-violation bit is set.
- R10: A frame whose first byte arrives in the cycle right after the previous frame's `rxEnd` is stored in full, starting in the next descriptor.
- R11: An `rxEnd` with no bytes stored since the previous frame end changes no descriptor and raises no event.
- R12: A frame that ends exactly on a buffer boundary is finalized in the descriptor it filled, and the following descriptor is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | An accepted receive byte is present |
| rxData | input | 8 | Receive byte, CRC bytes included |
| rxEnd | input | 1 | Frame end strobe, carries no byte |
| rxCrcErr | input | 1 | CRC failed, valid with rxEnd |
| rxAbort | input | 1 | Frame was aborted, valid with rxEnd |
| maxLen | input | LEN_W | Maximum number of bytes stored per frame |
| armValid | input | 1 | Arm the descriptor named by armIdx |
| armIdx | input | IDX_W | Descriptor to arm |
| armIntEn | input | 1 | Interrupt-enable value to arm with |
| armWrap | input | 1 | Wrap value to arm with |
| rdIdx | input | IDX_W | Descriptor to read back |
| rdPtr | input | PTR_W | Byte position to read back |
| rdCtrl | output | 4 | {last, wrap, intEn, empty} of rdIdx |
| rdLen | output | LEN_W | Length field of rdIdx |
| rdStatus | output | 3 | {lenViol, abort, crcErr} of rdIdx |
| rdByte | output | 8 | Stored byte at rdIdx/rdPtr |
| bufIrq | output | 1 | Buffer-full event pulse |
| frameIrq | output | 1 | Frame-received event pulse |
| busyIrq | output | 1 | No empty descriptor, frame dropped |

## Verification
The bench chases the places where a frame and the ring meet. These are a frame that ends exactly on a buffer boundary, a frame cut off by an owned descriptor partway through, one whose first descriptor is already owned, a frame truncated by the length limit, and a frame that starts in the cycle right after the previous one ended. A design that wrote only the last buffer's fill into the final length would report 4 instead of 12 for a two-buffer frame. A design that reset the byte count per buffer would miss the length violation. A design that advanced the pointer again at a boundary end would leave the wrong descriptor pending or finalize an empty one. A design that wrote before checking ownership would corrupt a descriptor software still holds, and that shows in the read-back comparison.

// File: rtl/hdlc_rx_bd_pkg.sv
package hdlc_rx_bd_pkg;
  // bit positions inside the read-back control nibble
  localparam int CTRL_EMPTY = 0;
  localparam int CTRL_INT   = 1;
  localparam int CTRL_WRAP  = 2;
  localparam int CTRL_LAST  = 3;
  // bit positions inside the status word
  localparam int STAT_CRC   = 0;
  localparam int STAT_ABORT = 1;
  localparam int STAT_LENV  = 2;
  localparam int STAT_W     = 3;

  // strobes from control to datapath, applied at the next edge
  typedef struct packed {
    logic              wrByte;     // store rxData at (tgtIdx, wrPtr)
    logic              closeFull;  // buffer tgtIdx just filled
    logic              finalize;   // close tgtIdx as the frame's last
    logic [STAT_W-1:0] finStatus;  // status word to write on finalize
  } bd_strobe_t;
endpackage

// File: rtl/hdlc_rx_bd_ctrl.sv
module hdlc_rx_bd_ctrl
  import hdlc_rx_bd_pkg::*;
#(
  parameter int NDESC     = 4,
  parameter int BUF_BYTES = 8,
  parameter int LEN_W     = 16,
  localparam int IDX_W    = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int PTR_W    = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxEnd,
  input  logic             rxCrcErr,
  input  logic             rxAbort,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             curEmpty,
  input  logic             curWrap,
  output logic [IDX_W-1:0] curIdx,
  output logic [IDX_W-1:0] tgtIdx,
  output logic [PTR_W-1:0] wrPtr,
  output logic [LEN_W-1:0] finLen,
  output bd_strobe_t       st,
  output logic             busyIrq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NDESC - 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(BUF_BYTES - 1);

  logic [PTR_W-1:0] fill;
  logic [LEN_W-1:0] frameLen;
  logic [IDX_W-1:0] lastIdx;
  logic             dropping;
  logic             overLen;

  logic [IDX_W-1:0] nextIdx;
  logic             byteIn, atLimit, acceptByte, startBusy, limitHit, fillsUp, doFinal;

  always_comb begin
    nextIdx    = (curWrap || curIdx == LAST_IDX) ? '0 : curIdx + 1'b1;
    byteIn     = rxValid && !rxEnd && !dropping;
    atLimit    = frameLen >= maxLen;
    limitHit   = byteIn && atLimit;
    startBusy  = byteIn && !atLimit && fill == '0 && !curEmpty;
    acceptByte = byteIn && !atLimit && (fill != '0 || curEmpty);
    fillsUp    = acceptByte && fill == LAST_PTR;
    doFinal    = rxEnd && !dropping && frameLen != '0;

    st.wrByte    = acceptByte;
    st.closeFull = fillsUp;
    st.finalize  = doFinal;
    st.finStatus = '0;
    st.finStatus[STAT_CRC]   = rxCrcErr;
    st.finStatus[STAT_ABORT] = rxAbort;
    st.finStatus[STAT_LENV]  = overLen;

    tgtIdx = doFinal ? lastIdx : curIdx;
    wrPtr  = fill;
    finLen = frameLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx   <= '0;
      lastIdx  <= '0;
      fill     <= '0;
      frameLen <= '0;
      dropping <= 1'b0;
      overLen  <= 1'b0;
      busyIrq  <= 1'b0;
    end else begin
      busyIrq <= startBusy;
      if (rxEnd) begin
        // a partly filled buffer is handed over, so move past it
        if (doFinal && fill != '0) curIdx <= nextIdx;
        fill     <= '0;
        frameLen <= '0;
        dropping <= 1'b0;
        overLen  <= 1'b0;
      end else begin
        if (limitHit)  overLen  <= 1'b1;
        if (startBusy) dropping <= 1'b1;
        if (acceptByte) begin
          frameLen <= frameLen + 1'b1;
          lastIdx  <= curIdx;
          if (fillsUp) begin
            fill   <= '0;
            curIdx <= nextIdx;
          end else begin
            fill <= fill + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_bd_store.sv
module hdlc_rx_bd_store
  import hdlc_rx_bd_pkg::*;
#(
  parameter int NDESC     = 4,
  parameter int BUF_BYTES = 8,
  parameter int LEN_W     = 16,
  localparam int IDX_W    = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int PTR_W    = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bd_strobe_t        st,
  input  logic [IDX_W-1:0]  tgtIdx,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [7:0]        wrData,
  input  logic [LEN_W-1:0]  finLen,
  input  logic [IDX_W-1:0]  curIdx,
  output logic              curEmpty,
  output logic              curWrap,
  input  logic              armValid,
  input  logic [IDX_W-1:0]  armIdx,
  input  logic              armIntEn,
  input  logic              armWrap,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [PTR_W-1:0]  rdPtr,
  output logic [3:0]        rdCtrl,
  output logic [LEN_W-1:0]  rdLen,
  output logic [STAT_W-1:0] rdStatus,
  output logic [7:0]        rdByte,
  output logic              bufIrq,
  output logic              frameIrq
);
  logic              emptyW [NDESC];
  logic              intW   [NDESC];
  logic              wrapW  [NDESC];
  logic              lastW  [NDESC];
  logic [LEN_W-1:0]  lenW   [NDESC];
  logic [STAT_W-1:0] statW  [NDESC];
  logic [7:0]        byteW  [NDESC];

  for (genvar d = 0; d < NDESC; d++) begin : g_desc
    logic              emptyQ, intQ, wrapQ, lastQ;
    logic [LEN_W-1:0]  lenQ;
    logic [STAT_W-1:0] statQ;
    logic [7:0]        mem [BUF_BYTES];
    logic              hit;

    assign hit = tgtIdx == IDX_W'(d);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        emptyQ <= 1'b0;
        intQ   <= 1'b0;
        wrapQ  <= 1'b0;
        lastQ  <= 1'b0;
        lenQ   <= '0;
        statQ  <= '0;
      end else begin
        if (armValid && armIdx == IDX_W'(d)) begin
          emptyQ <= 1'b1;
          intQ   <= armIntEn;
          wrapQ  <= armWrap;
          lastQ  <= 1'b0;
          lenQ   <= '0;
          statQ  <= '0;
        end
        if (st.closeFull && hit) begin
          emptyQ <= 1'b0;
          lenQ   <= LEN_W'(BUF_BYTES);
        end
        if (st.finalize && hit) begin
          emptyQ <= 1'b0;
          lastQ  <= 1'b1;
          lenQ   <= finLen;
          statQ  <= st.finStatus;
        end
      end
    end

    for (genvar p = 0; p < BUF_BYTES; p++) begin : g_byte
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mem[p] <= '0;
        else if (st.wrByte && hit && wrPtr == PTR_W'(p)) mem[p] <= wrData;
      end
    end

    assign emptyW[d] = emptyQ;
    assign intW[d]   = intQ;
    assign wrapW[d]  = wrapQ;
    assign lastW[d]  = lastQ;
    assign lenW[d]   = lenQ;
    assign statW[d]  = statQ;
    assign byteW[d]  = mem[rdPtr];
  end

  always_comb begin
    curEmpty = emptyW[curIdx];
    curWrap  = wrapW[curIdx];
    rdCtrl   = '0;
    rdCtrl[CTRL_EMPTY] = emptyW[rdIdx];
    rdCtrl[CTRL_INT]   = intW[rdIdx];
    rdCtrl[CTRL_WRAP]  = wrapW[rdIdx];
    rdCtrl[CTRL_LAST]  = lastW[rdIdx];
    rdLen    = lenW[rdIdx];
    rdStatus = statW[rdIdx];
    rdByte   = byteW[rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufIrq   <= 1'b0;
      frameIrq <= 1'b0;
    end else begin
      bufIrq   <= st.closeFull && intW[tgtIdx];
      frameIrq <= st.finalize && intW[tgtIdx];
    end
  end
endmodule

// File: rtl/hdlc_rx_bd_writer.sv
module hdlc_rx_bd_writer
  import hdlc_rx_bd_pkg::*;
#(
  parameter int NDESC     = 4,
  parameter int BUF_BYTES = 8,
  parameter int LEN_W     = 16,
  localparam int IDX_W    = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int PTR_W    = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxEnd,
  input  logic              rxCrcErr,
  input  logic              rxAbort,
  input  logic [LEN_W-1:0]  maxLen,
  input  logic              armValid,
  input  logic [IDX_W-1:0]  armIdx,
  input  logic              armIntEn,
  input  logic              armWrap,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [PTR_W-1:0]  rdPtr,
  output logic [3:0]        rdCtrl,
  output logic [LEN_W-1:0]  rdLen,
  output logic [STAT_W-1:0] rdStatus,
  output logic [7:0]        rdByte,
  output logic              bufIrq,
  output logic              frameIrq,
  output logic              busyIrq
);
  bd_strobe_t       st;
  logic [IDX_W-1:0] curIdx, tgtIdx;
  logic [PTR_W-1:0] wrPtr;
  logic [LEN_W-1:0] finLen;
  logic             curEmpty, curWrap;

  hdlc_rx_bd_ctrl #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxEnd(rxEnd),
    .rxCrcErr(rxCrcErr), .rxAbort(rxAbort), .maxLen(maxLen),
    .curEmpty(curEmpty), .curWrap(curWrap), .curIdx(curIdx), .tgtIdx(tgtIdx),
    .wrPtr(wrPtr), .finLen(finLen), .st(st), .busyIrq(busyIrq)
  );

  hdlc_rx_bd_store #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rstN(rstN), .st(st), .tgtIdx(tgtIdx), .wrPtr(wrPtr),
    .wrData(rxData), .finLen(finLen), .curIdx(curIdx), .curEmpty(curEmpty),
    .curWrap(curWrap), .armValid(armValid), .armIdx(armIdx), .armIntEn(armIntEn),
    .armWrap(armWrap), .rdIdx(rdIdx), .rdPtr(rdPtr), .rdCtrl(rdCtrl),
    .rdLen(rdLen), .rdStatus(rdStatus), .rdByte(rdByte),
    .bufIrq(bufIrq), .frameIrq(frameIrq)
  );
endmodule

// File: rtl/hdlc_rx_bd_chk.sv
module hdlc_rx_bd_chk (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic rxEnd,
  input logic bufIrq,
  input logic frameIrq,
  input logic busyIrq
);
  // R4: a buffer can only fill on a cycle that carried a byte
  a_r4_buf_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    bufIrq |-> $past(rxValid));

  // R7: frame event only follows a frame end strobe
  a_r7_frame_after_end: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |-> $past(rxEnd));

  // R7: two frame events never come back to back
  a_r7_frame_single: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |=> !frameIrq);

  // R3 / R6: busy only reacts to an arriving byte
  a_r3_busy_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    busyIrq |-> $past(rxValid));

  // R6: at most one event per cycle
  a_r6_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bufIrq, frameIrq, busyIrq}));

  // R11: an idle input cycle produces no event
  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!rxValid && !rxEnd) |=> !(bufIrq || frameIrq || busyIrq));
endmodule

bind hdlc_rx_bd_writer hdlc_rx_bd_chk u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxEnd(rxEnd),
  .bufIrq(bufIrq), .frameIrq(frameIrq), .busyIrq(busyIrq)
);

// File: tb/tb_hdlc_rx_bd_writer.sv
module tb_hdlc_rx_bd_writer;
  localparam int NDESC = 4;
  localparam int BUFB  = 8;
  localparam int LEN_W = 16;
  localparam int IDX_W = 2;
  localparam int PTR_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 0, rxEnd = 0, rxCrcErr = 0, rxAbort = 0;
  logic [7:0] rxData = 0;
  logic [LEN_W-1:0] maxLen = 16'd64;
  logic armValid = 0, armIntEn = 0, armWrap = 0;
  logic [IDX_W-1:0] armIdx = 0, rdIdx = 0;
  logic [PTR_W-1:0] rdPtr = 0;
  logic [3:0] rdCtrl;
  logic [LEN_W-1:0] rdLen;
  logic [2:0] rdStatus;
  logic [7:0] rdByte;
  logic bufIrq, frameIrq, busyIrq;

  always #10 clk = ~clk;  // 50 MHz

  hdlc_rx_bd_writer #(.NDESC(NDESC), .BUF_BYTES(BUFB), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxEnd(rxEnd),
    .rxCrcErr(rxCrcErr), .rxAbort(rxAbort), .maxLen(maxLen),
    .armValid(armValid), .armIdx(armIdx), .armIntEn(armIntEn), .armWrap(armWrap),
    .rdIdx(rdIdx), .rdPtr(rdPtr), .rdCtrl(rdCtrl), .rdLen(rdLen),
    .rdStatus(rdStatus), .rdByte(rdByte),
    .bufIrq(bufIrq), .frameIrq(frameIrq), .busyIrq(busyIrq)
  );

  int nChecks = 0, nFails = 0;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mEmpty[NDESC], mInt[NDESC], mWrap[NDESC], mLast[NDESC];
  int mLen[NDESC], mStat[NDESC];
  int mMem[NDESC][BUFB];
  int mCur, mFill, mCount, mPrev, mDrop, mOver;
  int eBuf, eFrm, eBusy;

  function automatic int ringNext(int i);
    return (mWrap[i] != 0 || i == NDESC - 1) ? 0 : i + 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < NDESC; d++) begin
        mEmpty[d] = 0; mInt[d] = 0; mWrap[d] = 0; mLast[d] = 0;
        mLen[d] = 0; mStat[d] = 0;
        for (int p = 0; p < BUFB; p++) mMem[d][p] = 0;
      end
      mCur = 0; mFill = 0; mCount = 0; mPrev = 0; mDrop = 0; mOver = 0;
      eBuf = 0; eFrm = 0; eBusy = 0;
    end else begin
      eBuf = 0; eFrm = 0; eBusy = 0;
      if (rxEnd) begin
        if (mDrop == 0 && mCount > 0) begin
          mEmpty[mPrev] = 0; mLast[mPrev] = 1; mLen[mPrev] = mCount;
          mStat[mPrev] = (rxCrcErr ? 1 : 0) + (rxAbort ? 2 : 0) + (mOver != 0 ? 4 : 0);
          eFrm = mInt[mPrev];
          if (mFill > 0) mCur = ringNext(mCur);
        end
        mFill = 0; mCount = 0; mDrop = 0; mOver = 0;
      end else if (rxValid && mDrop == 0) begin
        if (mCount >= int'(maxLen)) mOver = 1;
        else if (mFill == 0 && mEmpty[mCur] == 0) begin
          mDrop = 1; eBusy = 1;
        end else begin
          mMem[mCur][mFill] = int'(rxData);
          mCount++; mPrev = mCur; mFill++;
          if (mFill == BUFB) begin
            mEmpty[mCur] = 0; mLen[mCur] = BUFB; eBuf = mInt[mCur];
            mCur = ringNext(mCur); mFill = 0;
          end
        end
      end
      if (armValid) begin  // bench never arms a descriptor in use
        mEmpty[armIdx] = 1; mInt[armIdx] = armIntEn; mWrap[armIdx] = armWrap;
        mLast[armIdx] = 0; mLen[armIdx] = 0; mStat[armIdx] = 0;
      end
    end
  end

  // event outputs compared against the model on every clock
  always @(negedge clk) begin
    if (rstN) begin
      check("R4 bufIrq", int'(bufIrq), eBuf);
      check("R7 frameIrq", int'(frameIrq), eFrm);
      check("R3/R6 busyIrq", int'(busyIrq), eBusy);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic arm(int idx, bit ie, bit wr);
    @(negedge clk);
    rxValid = 0; rxEnd = 0;
    armValid = 1; armIdx = IDX_W'(idx); armIntEn = ie; armWrap = wr;
    @(negedge clk);
    armValid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 0; rxEnd = 0; armValid = 0;
    end
  endtask

  // leaves rxEnd high; the next task call overrides it
  task automatic frame(int n, int base, bit crc, bit ab);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxEnd = 0; rxValid = 1; rxData = 8'(base + i);
    end
    @(negedge clk);
    rxValid = 0; rxEnd = 1; rxCrcErr = crc; rxAbort = ab;
  endtask

  task automatic scan(string req);
    for (int d = 0; d < NDESC; d++) begin
      rdIdx = IDX_W'(d);
      rdPtr = '0;
      #1;
      check(req, int'(rdCtrl),
            mEmpty[d] + 2 * mInt[d] + 4 * mWrap[d] + 8 * mLast[d]);
      check(req, int'(rdLen), mLen[d]);
      check(req, int'(rdStatus), mStat[d]);
      for (int p = 0; p < BUFB; p++) begin
        rdPtr = PTR_W'(p);
        #1;
        check(req, int'(rdByte), mMem[d][p]);
      end
    end
  endtask

  task automatic peek(string req, int d, int ctrl, int len, int stat);
    rdIdx = IDX_W'(d); rdPtr = '0;
    #1;
    check(req, int'(rdCtrl), ctrl);
    check(req, int'(rdLen), len);
    check(req, int'(rdStatus), stat);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    check("R1 bufIrq in reset", int'(bufIrq), 0);
    rstN = 1;
    idle(2);
    scan("R1 reset state");
    check("R1 frameIrq", int'(frameIrq), 0);
    check("R1 busyIrq", int'(busyIrq), 0);

    // R2: arm all four
    arm(0, 1, 0); arm(1, 1, 0); arm(2, 0, 0); arm(3, 1, 1);
    idle(1);
    peek("R2 arm d3", 3, 4'b0111, 0, 0);
    peek("R2 arm d2", 2, 4'b0001, 0, 0);

    // R7: single-buffer frame
    frame(5, 8'h10, 0, 0);
    idle(2);
    peek("R7 final d0", 0, 4'b1010, 5, 0);
    rdPtr = 3'd4; #1;
    check("R3 byte order", int'(rdByte), 8'h14);

    // R10 / R5 / R8: two-buffer frame then back-to-back frame
    frame(12, 8'h40, 1, 0);
    frame(3, 8'h80, 0, 1);
    idle(2);
    peek("R4 full d1", 1, 4'b0010, 8, 0);
    peek("R7 total length d2", 2, 4'b1000, 12, 3'b001);
    peek("R10 R8 abort d3", 3, 4'b1110, 3, 3'b010);
    rdPtr = 3'd0; #1;
    check("R10 first byte", int'(rdByte), 8'h80);
    scan("R5 ring state");

    // R3: first descriptor owned by software, frame dropped
    frame(3, 8'hA0, 0, 0);
    idle(2);
    peek("R3 untouched d0", 0, 4'b1010, 5, 0);

    // R9: length limit across buffers
    arm(0, 1, 0); arm(1, 1, 0);
    maxLen = 16'd10;
    frame(20, 8'hC0, 0, 0);
    idle(2);
    peek("R9 first buffer", 0, 4'b0010, 8, 0);
    peek("R9 truncated", 1, 4'b1010, 10, 3'b100);
    maxLen = 16'd64;

    // R6: second buffer needed but owned
    arm(2, 0, 0);
    frame(12, 8'h20, 0, 0);
    idle(2);
    peek("R6 filled d2", 2, 4'b0000, 8, 0);
    peek("R6 untouched d3", 3, 4'b1110, 3, 3'b010);

    // R11: end with no bytes
    @(negedge clk); rxEnd = 1; rxCrcErr = 1;
    idle(2);
    scan("R11 no change");

    // R12: frame ending on buffer boundary, then wrap to d0
    arm(3, 1, 1); arm(0, 0, 0);
    frame(8, 8'h55, 0, 0);
    idle(2);
    peek("R12 boundary final", 3, 4'b1110, 8, 0);
    peek("R12 next untouched", 0, 4'b0001, 0, 0);
    frame(2, 8'h66, 0, 0);
    idle(2);
    peek("R5 wrapped to d0", 0, 4'b1000, 2, 0);
    scan("R12 final state");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule